// File: doc/BRIEF.md
# Prescaled Multi-Mode Timer

A general-purpose timer for a system-clocked subsystem. A down-counter advances once per prescaler tick. The prescaler divides the system clock by a power of two, chosen by a small exponent field. Software-style configuration inputs pick one of four modes:

- **Counted shots.** The counter runs a programmed number of reload periods and then stops.
- **Free-running.** The counter reloads without end.
- **Input capture.** A rising edge on an asynchronous input is synchronised, and the current count is latched.
- **Frozen.** The counter is held.

Every expiry and every capture raises a one-cycle interrupt pulse. Expiries also set a sticky status flag.

A start strobe arms the counter with the reload value and the shot count. The enable input gates counting without losing the count, so firmware can pause and resume a measurement.

Top module: `tmr_core`

## Requirements
- R1: After reset the count, the captured value, the expired flag and the interrupt are all zero.
- R2: While enabled, the counter steps once every 2^p enabled cycles, where p is the 3-bit prescale value (0..7). The first step after a start lands on the 2^p-th enabled edge.
- R3: Free-run (mode code 1) reloads on the step that would reach zero and raises an expiry each time, so the period is reload × 2^p cycles. A reload of 0 behaves as 1.
- R4: Shot mode (mode code 0) runs N reload periods, where N is the shot count and 0 behaves as 1. After the last expiry the count is 0 and no further expiry occurs until the next start.
- R5: In capture mode (mode code 2) with enable high, a rising input edge latches the count into the capture register and pulses the interrupt. The latch happens on the third clock edge after the input rises and takes the count held just before that edge. Falling edges, and rising edges while enable is low, change nothing.
- R6: In capture mode the counter wraps at reload silently: no interrupt and no expired flag.
- R7: With enable low the count holds, no step occurs, and the prescaler phase is cleared, so a full 2^p enabled cycles pass after re-enable before the next step.
- R8: A start strobe loads max(reload,1) and the shot count, and clears the prescaler phase. It takes priority over an expiry due on the same edge, which is then dropped.
- R9: The expired flag sets on every expiry and stays set until the clear input is high on an edge without an expiry. A set on the same edge wins over the clear.
- R10: The interrupt is high for the cycle following each expiry or capture edge, and low otherwise.
- R11: In frozen mode (mode code 3) the count holds its loaded value and no events occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_en | input | 1 | Counting enable |
| tmr_start | input | 1 | Arm strobe: load reload and shot count |
| tmr_mode | input | 2 | 0 shots, 1 free-run, 2 capture, 3 frozen |
| tmr_prescale | input | PRE_W (3) | Division exponent p, rate clk/2^p |
| tmr_reload | input | CNT_W (24) | Reload value |
| tmr_shots | input | SHOT_W (8) | Number of periods in shot mode |
| flag_clr | input | 1 | Clears the expired flag |
| cap_in | input | 1 | Asynchronous capture input |
| cnt_value | output | CNT_W (24) | Current count |
| cap_value | output | CNT_W (24) | Last captured count |
| expired | output | 1 | Sticky expiry flag |
| irq | output | 1 | Interrupt pulse |

## Verification
The bench builds the block with its defaults: a 24-bit counter, a 3-bit prescale exponent, an 8-bit shot count and two synchroniser stages. Small reload values bring both free-run wrap-around and the end of a counted run into a few dozen cycles. The full exponent of 7 is reached with a single-step reload, so the 128-cycle prescaler boundary is checked directly. The zero-reload and zero-shot substitutions, a start strobe colliding with an expiry, and the prescaler phase cleared by a pause are each set up explicitly.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_SHOT = 2'd0,
    MODE_FREE = 2'd1,
    MODE_CAPT = 2'd2,
    MODE_HOLD = 2'd3
  } tmr_mode_e;

  // Modes in which the down-counter advances on a tick
  function automatic logic mode_counts(tmr_mode_e m);
    return (m != MODE_HOLD);
  endfunction

  // Modes in which reaching the end of a period is an expiry event
  function automatic logic mode_expires(tmr_mode_e m);
    return (m == MODE_SHOT) || (m == MODE_FREE);
  endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PRE_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             restart,
  input  logic [PRE_W-1:0] ps,
  output logic             tick
);
  localparam int PH_W = (1 << PRE_W) - 1;

  logic [PH_W-1:0] phase;
  logic [PH_W:0]   wide_mask;
  logic [PH_W-1:0] mask;

  // Low ps bits of the phase all ones marks the last cycle of a period
  always_comb begin
    wide_mask = ({{PH_W{1'b0}}, 1'b1} << ps) - 1'b1;
    mask      = wide_mask[PH_W-1:0];
    tick      = en && !restart && ((phase & mask) == mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              phase <= '0;
    else if (!en || restart) phase <= '0;
    else                     phase <= phase + 1'b1;
  end
endmodule

// File: rtl/tmr_sync.sv
module tmr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-1:0], din};
  end

  assign rise = chain[STAGES-1] && !chain[STAGES];

  // An edge detector cannot report two rises on consecutive cycles
  assert_single_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int SHOT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              start,
  input  tmr_mode_e         mode,
  input  logic [CNT_W-1:0]  reload,
  input  logic [SHOT_W-1:0] shots,
  input  logic              tick,
  input  logic              cap_rise,
  input  logic              flag_clr,
  output logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  cap_value,
  output logic              expired,
  output logic              irq,
  output logic              exp_evt,
  output logic              cap_evt
);
  logic [CNT_W-1:0]  reload_eff;
  logic [SHOT_W-1:0] shots_eff;
  logic [SHOT_W-1:0] shots_left;
  logic              running;
  logic              step;
  logic              at_end;
  logic              last_shot;

  // Zero programming values are promoted to one
  function automatic logic [CNT_W-1:0] eff_reload(logic [CNT_W-1:0] v);
    return (v == '0) ? CNT_W'(1) : v;
  endfunction

  function automatic logic [SHOT_W-1:0] eff_shots(logic [SHOT_W-1:0] v);
    return (v == '0) ? SHOT_W'(1) : v;
  endfunction

  always_comb begin
    reload_eff = eff_reload(reload);
    shots_eff  = eff_shots(shots);
    step       = running && mode_counts(mode) && tick && !start;
    at_end     = step && (count <= CNT_W'(1));
    exp_evt    = at_end && mode_expires(mode);
    last_shot  = (mode == MODE_SHOT) && (shots_left <= SHOT_W'(1));
    cap_evt    = cap_rise && en && (mode == MODE_CAPT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count      <= '0;
      shots_left <= '0;
      running    <= 1'b0;
    end else if (start) begin
      count      <= reload_eff;
      shots_left <= shots_eff;
      running    <= 1'b1;
    end else if (step) begin
      if (count <= CNT_W'(1)) begin
        if (last_shot) begin
          count   <= '0;
          running <= 1'b0;
        end else begin
          count <= reload_eff;
          if (mode == MODE_SHOT) shots_left <= shots_left - 1'b1;
        end
      end else begin
        count <= count - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_value <= '0;
      expired   <= 1'b0;
      irq       <= 1'b0;
    end else begin
      irq <= exp_evt || cap_evt;
      if (cap_evt)       cap_value <= count;
      if (exp_evt)       expired   <= 1'b1;
      else if (flag_clr) expired   <= 1'b0;
    end
  end

  assert_hold_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !start) |=> $stable(count));

  assert_idle_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !start) |=> (count == '0));

  assert_hold_mode_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_HOLD && !start) |=> $stable(count));

  assert_cap_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_evt |=> $stable(cap_value));

  assert_flag_on_expiry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    exp_evt |=> expired);

  assert_irq_on_event_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (exp_evt || cap_evt) |=> irq);
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int CNT_W       = 24,
  parameter int PRE_W       = 3,
  parameter int SHOT_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tmr_en,
  input  logic              tmr_start,
  input  logic [1:0]        tmr_mode,
  input  logic [PRE_W-1:0]  tmr_prescale,
  input  logic [CNT_W-1:0]  tmr_reload,
  input  logic [SHOT_W-1:0] tmr_shots,
  input  logic              flag_clr,
  input  logic              cap_in,
  output logic [CNT_W-1:0]  cnt_value,
  output logic [CNT_W-1:0]  cap_value,
  output logic              expired,
  output logic              irq
);
  tmr_mode_e mode;
  logic      tick;
  logic      cap_rise;
  logic      exp_evt;
  logic      cap_evt;

  assign mode = tmr_mode_e'(tmr_mode);

  tmr_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .en(tmr_en), .restart(tmr_start),
    .ps(tmr_prescale), .tick(tick)
  );

  tmr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(cap_in), .rise(cap_rise)
  );

  tmr_counter #(.CNT_W(CNT_W), .SHOT_W(SHOT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(tmr_en), .start(tmr_start), .mode(mode),
    .reload(tmr_reload), .shots(tmr_shots), .tick(tick), .cap_rise(cap_rise),
    .flag_clr(flag_clr), .count(cnt_value), .cap_value(cap_value),
    .expired(expired), .irq(irq), .exp_evt(exp_evt), .cap_evt(cap_evt)
  );

  // A step needs enable, so a disabled timer raises no expiry
  assert_no_expiry_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !tmr_en |-> !exp_evt);
endmodule

// File: tb/tmr_core_tb_top.sv
module tmr_core_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [1:0]  mode;
    logic [2:0]  ps;
    logic [23:0] rl;
    logic [7:0]  shots;
    int          k;
    int          exp_cnt;
    int          exp_irq;
    int          exp_flag;
  } vec_t;

  // mode, prescale, reload, shots, enabled cycles, count, irq pulses, flag
  localparam vec_t VEC [10] = '{
    '{2'd1, 3'd0, 24'd5, 8'd0,   3, 2, 0, 0},  // R3
    '{2'd1, 3'd0, 24'd5, 8'd0,   5, 5, 1, 1},  // R3
    '{2'd1, 3'd2, 24'd4, 8'd0,   9, 2, 0, 0},  // R2
    '{2'd1, 3'd1, 24'd3, 8'd0,  13, 3, 2, 1},  // R2
    '{2'd0, 3'd0, 24'd4, 8'd2,   7, 1, 1, 1},  // R4
    '{2'd0, 3'd0, 24'd4, 8'd2,  20, 0, 2, 1},  // R4
    '{2'd0, 3'd3, 24'd2, 8'd1,  15, 1, 0, 0},  // R2
    '{2'd0, 3'd7, 24'd1, 8'd1, 128, 0, 1, 1},  // R2
    '{2'd1, 3'd0, 24'd0, 8'd0,   3, 1, 3, 1},  // R3 zero reload
    '{2'd0, 3'd0, 24'd3, 8'd0,   3, 0, 1, 1}   // R4 zero shots
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tmr_en = 1'b0;
  logic        tmr_start = 1'b0;
  logic [1:0]  tmr_mode = 2'd0;
  logic [2:0]  tmr_prescale = 3'd0;
  logic [23:0] tmr_reload = '0;
  logic [7:0]  tmr_shots = '0;
  logic        flag_clr = 1'b0;
  logic        cap_in = 1'b0;
  logic [23:0] cnt_value;
  logic [23:0] cap_value;
  logic        expired;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_core dut_i (
    .clk(clk), .rst_n(rst_n), .tmr_en(tmr_en), .tmr_start(tmr_start),
    .tmr_mode(tmr_mode), .tmr_prescale(tmr_prescale), .tmr_reload(tmr_reload),
    .tmr_shots(tmr_shots), .flag_clr(flag_clr), .cap_in(cap_in),
    .cnt_value(cnt_value), .cap_value(cap_value), .expired(expired), .irq(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Arm the timer; returns at the negedge after the start edge
  task automatic arm(input logic [1:0] m, input logic [2:0] p,
                     input logic [23:0] r, input logic [7:0] s);
    tmr_mode = m; tmr_prescale = p; tmr_reload = r; tmr_shots = s;
    tmr_en = 1'b1; tmr_start = 1'b1; flag_clr = 1'b1;
    @(posedge clk); @(negedge clk);
    tmr_start = 1'b0; flag_clr = 1'b0;
  endtask

  task automatic run(input int k, output int nirq);
    nirq = 0;
    repeat (k) begin
      @(posedge clk); @(negedge clk);
      if (irq) nirq++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int ni;
    int snap;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 count", int'(cnt_value), 0);
    check("R1 capture", int'(cap_value), 0);
    check("R1 flag", int'(expired), 0);
    check("R1 irq", int'(irq), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Vector table
    for (int i = 0; i < 10; i++) begin
      arm(VEC[i].mode, VEC[i].ps, VEC[i].rl, VEC[i].shots);
      run(VEC[i].k, ni);
      check($sformatf("R2/R3/R4 vec%0d count", i), int'(cnt_value), VEC[i].exp_cnt);
      check($sformatf("R10 vec%0d irq pulses", i), ni, VEC[i].exp_irq);
      check($sformatf("R9 vec%0d flag", i), int'(expired), VEC[i].exp_flag);
    end

    // R9: clear alone drops the flag; set wins over a concurrent clear
    flag_clr = 1'b1; @(posedge clk); @(negedge clk); flag_clr = 1'b0;
    check("R9 cleared", int'(expired), 0);
    arm(2'd1, 3'd0, 24'd1, 8'd0);
    flag_clr = 1'b1; run(3, ni); flag_clr = 1'b0;
    check("R9 set wins", int'(expired), 1);

    // R7: disable holds the count
    arm(2'd1, 3'd0, 24'd10, 8'd0);
    run(3, ni);
    check("R7 running", int'(cnt_value), 7);
    tmr_en = 1'b0; run(5, ni);
    check("R7 held", int'(cnt_value), 7);
    check("R7 no irq", ni, 0);

    // R7: prescaler phase cleared by a pause
    arm(2'd1, 3'd2, 24'd10, 8'd0);
    run(6, ni);
    check("R7 first step", int'(cnt_value), 9);
    tmr_en = 1'b0; run(2, ni); tmr_en = 1'b1;
    run(3, ni);
    check("R7 phase cleared", int'(cnt_value), 9);
    run(1, ni);
    check("R7 full period", int'(cnt_value), 8);

    // R8: restart mid-count, and start beats a due expiry
    arm(2'd1, 3'd0, 24'd10, 8'd0);
    run(3, ni);
    arm(2'd1, 3'd0, 24'd10, 8'd0);
    check("R8 reload", int'(cnt_value), 10);
    arm(2'd1, 3'd0, 24'd2, 8'd0);
    run(1, ni);
    check("R8 pre", int'(cnt_value), 1);
    arm(2'd1, 3'd0, 24'd2, 8'd0);
    check("R8 start wins", int'(cnt_value), 2);
    check("R8 expiry dropped", int'(irq), 0);

    // R11: frozen mode
    arm(2'd3, 3'd0, 24'd6, 8'd0);
    run(5, ni);
    check("R11 frozen count", int'(cnt_value), 6);
    check("R11 no irq", ni, 0);

    // R6: capture mode wraps silently
    arm(2'd2, 3'd0, 24'd3, 8'd0);
    run(10, ni);
    check("R6 count", int'(cnt_value), 2);
    check("R6 no irq", ni, 0);
    check("R6 no flag", int'(expired), 0);

    // R5: capture latency and value
    arm(2'd2, 3'd0, 24'd100, 8'd0);
    run(5, ni);
    cap_in = 1'b1;
    run(2, ni);
    snap = int'(cnt_value);
    check("R5 count before capture", snap, 93);
    run(1, ni);
    check("R5 captured", int'(cap_value), 93);
    check("R5 irq", int'(irq), 1);
    run(1, ni);
    check("R10 irq single", int'(irq), 0);
    cap_in = 1'b0; run(4, ni);
    check("R5 falling ignored", int'(cap_value), 93);
    check("R5 falling no irq", ni, 0);
    tmr_en = 1'b0; cap_in = 1'b1; run(4, ni);
    check("R5 disabled capture", int'(cap_value), 93);
    check("R5 disabled no irq", ni, 0);
    check("R5 no flag", int'(expired), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule